// File: doc/BRIEF.md
# MDIO Management Controller

This block lets software reach the management registers of an Ethernet PHY over the two-wire MDIO interface. It uses the Clause 22 frame format. The control side is a small word-wide register port with two registers. Software builds a command word with these fields:

- the operation
- the PHY address
- the register address
- for a write, 16 bits of payload

Software writes that word with the fire bit set. The controller then sends the whole frame on the serial pins and clears fire when it is done. For a read, the 16 bits returned by the PHY land in the low half of the second register.

Software waits for the end of a transaction by polling the idle flag in the second register. Commands that name a start code other than Clause 22 are rejected at once, with no activity on the management pins. Commands whose operation field is malformed are handled the same way. A command written while a frame is still on the wire is dropped. The management clock comes from the system clock through an even divider, set by a parameter, so the wire rate stays within the PHY's limit.

Top module: `mdio_ctrl`

## Requirements
- R1: After reset the command register reads 0x0000_0000 and the data register reads 0x0001_0000 (idle set). MDC is low and MDIO is released (output enable low).
- R2: The command register is at byte offset 0x0 and the data register at 0x4. Any other offset reads zero and ignores writes.
- R3: A command write with bit 31 (fire) set, bit 28 (Clause 22 select) set and exactly one of bit 27 (read) or bit 26 (write) set starts a transaction. From the next cycle, fire reads 1 and bit 16 of the data register (idle) reads 0. On completion fire reads 0, idle reads 1, and the other command bits read back as written.
- R4: A write sends 64 bits, MSB first, changing MDIO only while MDC is low. The bits are 32 ones, start 01, opcode 01, the PHY address (command bits 25:21), the register address (bits 20:16), turnaround 10, and the payload (bits 15:0).
- R5: A read sends the same header with opcode 10. MDIO is released from the first turnaround bit to the end of the frame. The 16 data bits are sampled on the rising edge of MDC. On completion they replace bits 15:0 of the data register, and bits 31:17 are kept.
- R6: A fire command with bit 28 clear runs no frame. The next cycle fire reads 0 and idle reads 1, and MDC does not toggle.
- R7: A fire command with bits 27 and 26 both clear or both set runs no frame. The next cycle fire reads 0 and idle reads 1, and MDC does not toggle.
- R8: A command-register write while a transaction runs is ignored. The command register keeps its contents and only one frame appears.
- R9: Software can write bits 31:17 of the data register. Bits 16:0 ignore writes.
- R10: MDC has a period of DIV system clocks and is high for DIV/2 of them. It stays low when idle. A transaction keeps idle at 0 for exactly 64*DIV cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Full-word write strobe |
| bus_addr | input | AW | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data driven toward the PHY |
| mdio_oe | output | 1 | High while the controller drives MDIO |
| mdio_i | input | 1 | Serial data seen on the MDIO line |

## Verification
A controller that is still marked busy after a frame would leave idle at 0 past the 64*DIV-cycle window. A busy flag that ends too early shows up in the same window. A frame shift register or bit counter that is out of step corrupts the header seen by the PHY responder within one frame, or samples read data one bit off. Either fault is visible in the captured bit stream or in the data register as soon as idle rises. A reject path that leaks into the engine shows up as MDC edges within a few DIV periods of the rejected write.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int CMD_FIRE  = 31;
  localparam int CMD_C22   = 28;
  localparam int CMD_RD    = 27;
  localparam int CMD_WR    = 26;
  localparam int PHY_LSB   = 21;
  localparam int REGA_LSB  = 16;
  localparam int FRAME_LEN = 64;
  localparam int TA_IDX    = 46;
  localparam int DATA_IDX  = 48;
  localparam int IDX_W     = $clog2(FRAME_LEN);

  typedef struct packed {
    logic        is_rd;
    logic [4:0]  phy;
    logic [4:0]  rega;
    logic [15:0] wdat;
  } mdio_req_t;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic mdc_q, mdc_d, tick;

  generate
    if (HALF > 1) begin : g_cnt
      logic [CW-1:0] cnt_q, cnt_d;
      always_comb begin
        tick  = en && (cnt_q == CW'(HALF - 1));
        cnt_d = cnt_q;
        if (!en || tick) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
    end else begin : g_nocnt
      always_comb tick = en;
    end
  endgenerate

  always_comb begin
    mdc_d = mdc_q;
    if (!en)       mdc_d = 1'b0;
    else if (tick) mdc_d = ~mdc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mdc_q <= 1'b0;
    else        mdc_q <= mdc_d;
  end

  assign mdc       = mdc_q;
  assign rise_tick = tick && !mdc_q;
  assign fall_tick = tick && mdc_q;
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mdio_req_t   req,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        mdio_i,
  output logic        active,
  output logic        done,
  output logic [15:0] rx_data,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic                 act_q, act_d, rd_q, rd_d;
  logic [FRAME_LEN-1:0] sh_q, sh_d, frame;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [15:0]          rx_q, rx_d;

  always_comb begin
    frame = {32'hFFFF_FFFF, 2'b01, (req.is_rd ? 2'b10 : 2'b01), req.phy, req.rega,
             (req.is_rd ? 2'b00 : 2'b10), (req.is_rd ? 16'h0000 : req.wdat)};
    act_d = act_q;
    rd_d  = rd_q;
    sh_d  = sh_q;
    idx_d = idx_q;
    rx_d  = rx_q;
    done  = 1'b0;
    if (start && !act_q) begin
      act_d = 1'b1;
      rd_d  = req.is_rd;
      sh_d  = frame;
      idx_d = '0;
      rx_d  = '0;
    end else if (act_q) begin
      if (rise_tick && rd_q && (idx_q >= IDX_W'(DATA_IDX)))
        rx_d = {rx_q[14:0], mdio_i};
      if (fall_tick) begin
        if (idx_q == IDX_W'(FRAME_LEN - 1)) begin
          act_d = 1'b0;
          done  = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
          sh_d  = {sh_q[FRAME_LEN-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      rd_q  <= 1'b0;
      sh_q  <= '0;
      idx_q <= '0;
      rx_q  <= '0;
    end else begin
      act_q <= act_d;
      rd_q  <= rd_d;
      sh_q  <= sh_d;
      idx_q <= idx_d;
      rx_q  <= rx_d;
    end
  end

  assign active  = act_q;
  assign rx_data = rx_q;
  assign mdio_o  = act_q && sh_q[FRAME_LEN-1];
  assign mdio_oe = act_q && !(rd_q && (idx_q >= IDX_W'(TA_IDX)));

  // R8: the register side never asks for a frame while one is running
  p_single_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !act_q);
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV = 80,
  parameter int AW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          mdc,
  output logic          mdio_o,
  output logic          mdio_oe,
  input  logic          mdio_i
);
  localparam logic [AW-1:0] OFS_CMD = AW'(0);
  localparam logic [AW-1:0] OFS_DAT = AW'(4);

  logic [30:0] cmd_q, cmd_d;
  logic        busy_q, busy_d;
  logic [15:0] rdat_q, rdat_d;
  logic [14:0] hi_q, hi_d;
  logic        wr_cmd, wr_dat, op_ok, launch, done, eng_active;
  logic        rise_tick, fall_tick;
  logic [15:0] rx_data;
  mdio_req_t   req;

  assign wr_cmd = bus_wr && (bus_addr == OFS_CMD);
  assign wr_dat = bus_wr && (bus_addr == OFS_DAT);
  assign op_ok  = bus_wdata[CMD_RD] ^ bus_wdata[CMD_WR];
  assign launch = wr_cmd && !busy_q && bus_wdata[CMD_FIRE] && bus_wdata[CMD_C22] && op_ok;

  assign req.is_rd = bus_wdata[CMD_RD];
  assign req.phy   = bus_wdata[PHY_LSB +: 5];
  assign req.rega  = bus_wdata[REGA_LSB +: 5];
  assign req.wdat  = bus_wdata[15:0];

  always_comb begin
    cmd_d  = cmd_q;
    busy_d = busy_q;
    rdat_d = rdat_q;
    hi_d   = hi_q;
    if (wr_cmd && !busy_q) cmd_d = bus_wdata[30:0];
    if (launch)    busy_d = 1'b1;
    else if (done) busy_d = 1'b0;
    if (done && cmd_q[CMD_RD]) rdat_d = rx_data;
    if (wr_dat) hi_d = bus_wdata[31:17];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      busy_q <= 1'b0;
      rdat_q <= '0;
      hi_q   <= '0;
    end else begin
      cmd_q  <= cmd_d;
      busy_q <= busy_d;
      rdat_q <= rdat_d;
      hi_q   <= hi_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_CMD)      bus_rdata = {busy_q, cmd_q};
    else if (bus_addr == OFS_DAT) bus_rdata = {hi_q, ~busy_q, rdat_q};
  end

  mdio_clkdiv #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .en(eng_active),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame u_frame (
    .clk(clk), .rst_n(rst_n), .start(launch), .req(req),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .active(eng_active), .done(done), .rx_data(rx_data),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  // R3: completion only ever ends a transaction that was started
  p_done_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy_q);
  // R4: serial data moves only while the management clock is low
  p_mdio_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$stable(mdio_o)) |-> !mdc);
  // R6: fire without Clause 22 select leaves the block idle
  p_reject_st_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !busy_q && bus_wdata[CMD_FIRE] && !bus_wdata[CMD_C22]) |=> !busy_q);
  // R7: malformed operation leaves the block idle
  p_reject_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !busy_q && bus_wdata[CMD_FIRE] && (bus_wdata[CMD_RD] == bus_wdata[CMD_WR]))
    |=> !busy_q);
  // R8: command contents frozen while a frame runs
  p_hold_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr_cmd) |=> $stable(cmd_q));
  // R9: software writes never touch the returned read data
  p_keep_rdat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && !done) |=> $stable(rdat_q));
  // R10: management clock rests low whenever no transaction runs
  p_mdc_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mdc);
endmodule

// File: tb/mdio_ctrl_test.sv
`timescale 1ns/1ps
module mdio_ctrl_test;
  localparam int DIV = 8;
  localparam int AW  = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          mdc, mdio_o, mdio_oe;
  logic          phy_drv = 1'b1;
  logic          line;

  int checks = 0;
  int fails = 0;

  typedef struct packed {
    logic [63:0] line;
    logic [63:0] oe;
  } exp_t;
  exp_t exp_q[$];

  logic [63:0] cap_line, cap_oe;
  int          phy_bit = 64;
  int          mdc_rises = 0;
  int          frames_seen = 0;
  logic [15:0] phy_resp = 16'h0000;

  always #2.5 clk = ~clk;

  assign line = mdio_oe ? mdio_o : phy_drv;

  mdio_ctrl #(.DIV(DIV), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(phy_drv)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // PHY responder and scoreboard monitor
  always @(posedge mdc) begin
    mdc_rises++;
    if (phy_bit < 64) begin
      cap_line[63-phy_bit] = line;
      cap_oe[63-phy_bit]   = mdio_oe;
      phy_bit++;
      if (phy_bit == 64) begin
        exp_t e;
        frames_seen++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected frame", cap_line, 64'h0);
        end else begin
          e = exp_q.pop_front();
          check(cap_line == e.line, "R4/R5 frame bits", cap_line, e.line);
          check(cap_oe == e.oe, "R5 drive enable", cap_oe, e.oe);
        end
      end
    end
  end

  always @(negedge mdc) begin
    if (phy_bit == 47)                     phy_drv = 1'b0;
    else if (phy_bit >= 48 && phy_bit < 64) phy_drv = phy_resp[63-phy_bit];
    else                                   phy_drv = 1'b1;
  end

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle(output int busy_cyc, output int hi_cyc);
    logic [31:0] d;
    busy_cyc = 0; hi_cyc = 0;
    for (int i = 0; i < 4000; i++) begin
      bus_read(AW'(4), d);
      if (d[16]) break;
      busy_cyc++;
      if (mdc) hi_cyc++;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] mk_cmd(input bit rd, input logic [4:0] phy,
                                         input logic [4:0] ra, input logic [15:0] wd);
    return {1'b1, 2'b00, 1'b1, rd, !rd, phy, ra, wd};
  endfunction

  task automatic push_exp(input bit rd, input logic [4:0] phy, input logic [4:0] ra,
                          input logic [15:0] wd);
    exp_t e;
    if (rd) begin
      e.line = {32'hFFFF_FFFF, 2'b01, 2'b10, phy, ra, 2'b10, phy_resp};
      e.oe   = 64'hFFFF_FFFF_FFFC_0000;
    end else begin
      e.line = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, ra, 2'b10, wd};
      e.oe   = 64'hFFFF_FFFF_FFFF_FFFF;
    end
    exp_q.push_back(e);
    phy_bit = 0;
  endtask

  task automatic reject_case(input logic [31:0] c, input string req);
    logic [31:0] d;
    int r0;
    r0 = mdc_rises;
    bus_write(AW'(0), c);
    bus_read(AW'(0), d);
    check(d == {1'b0, c[30:0]}, req, d, {1'b0, c[30:0]});
    bus_read(AW'(4), d);
    check(d[16] == 1'b1, req, d, 32'h0001_0000);
    repeat (4 * DIV) @(negedge clk);
    check(mdc_rises == r0, req, mdc_rises, r0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d, c;
    int bc, hc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(AW'(0), d);
    check(d == 32'h0, "R1 command reset", d, 32'h0);
    bus_read(AW'(4), d);
    check(d == 32'h0001_0000, "R1 data reset", d, 32'h0001_0000);
    check({mdc, mdio_oe} == 2'b00, "R1 pins idle", {mdc, mdio_oe}, 2'b00);

    // R9 upper bits writable, low bits not
    bus_write(AW'(4), 32'hFFFF_FFFF);
    bus_read(AW'(4), d);
    check(d == 32'hFFFF_0000, "R9 data write", d, 32'hFFFF_0000);

    // R3/R4/R10 write transaction
    c = mk_cmd(1'b0, 5'd5, 5'd3, 16'hA5C3);
    push_exp(1'b0, 5'd5, 5'd3, 16'hA5C3);
    bus_write(AW'(0), c);
    bus_read(AW'(0), d);
    check(d == c, "R3 fire reads 1", d, c);
    wait_idle(bc, hc);
    check(bc == 64 * DIV, "R10 busy length", bc, 64 * DIV);
    check(hc == 32 * DIV, "R10 mdc high time", hc, 32 * DIV);
    bus_read(AW'(0), d);
    check(d == {1'b0, c[30:0]}, "R3 fire cleared", d, {1'b0, c[30:0]});
    bus_read(AW'(4), d);
    check(d == 32'hFFFF_0000, "R3 idle set, data kept", d, 32'hFFFF_0000);

    // R5/R8 read transaction with a second command during it
    phy_resp = 16'hBEEF;
    c = mk_cmd(1'b1, 5'h1F, 5'h02, 16'h0000);
    push_exp(1'b1, 5'h1F, 5'h02, 16'h0000);
    bus_write(AW'(0), c);
    bus_read(AW'(4), d);
    check(d[16] == 1'b0, "R3 idle reads 0", d, 32'h0);
    bus_write(AW'(0), mk_cmd(1'b0, 5'd1, 5'd1, 16'h1111));
    bus_read(AW'(0), d);
    check(d == c, "R8 command held", d, c);
    wait_idle(bc, hc);
    bus_read(AW'(4), d);
    check(d == 32'hFFFF_BEEF, "R5 read data", d, 32'hFFFF_BEEF);

    // R5 second read pattern
    phy_resp = 16'h0001;
    push_exp(1'b1, 5'h00, 5'h1F, 16'h0000);
    bus_write(AW'(0), mk_cmd(1'b1, 5'h00, 5'h1F, 16'h0000));
    wait_idle(bc, hc);
    bus_read(AW'(4), d);
    check(d == 32'hFFFF_0001, "R5 read data 2", d, 32'hFFFF_0001);

    // R9 low field not writable
    bus_write(AW'(4), 32'h0000_1234);
    bus_read(AW'(4), d);
    check(d == 32'h0001_0001, "R9 low bits kept", d, 32'h0001_0001);

    // R6 start select clear, R7 malformed op
    reject_case(32'h8800_0000 | 32'h0042_0055, "R6 no C22 select");
    reject_case(32'h9000_1234, "R7 no op");
    reject_case(32'h9C21_5678, "R7 both ops");

    // R2 unmapped offset
    c = mdc_rises;
    bus_write(AW'(2), mk_cmd(1'b0, 5'd2, 5'd2, 16'h2222));
    bus_read(AW'(2), d);
    check(d == 32'h0, "R2 unmapped read", d, 32'h0);
    repeat (4 * DIV) @(negedge clk);
    check(mdc_rises == int'(c), "R2 unmapped write ignored", mdc_rises, c);
    bus_read(AW'(0), d);
    check(d == 32'h1C21_5678, "R2 command untouched", d, 32'h1C21_5678);

    check(frames_seen == 3, "R8 frame count", frames_seen, 3);
    check(exp_q.size() == 0, "R4 all frames seen", exp_q.size(), 0);
    finish_run();
  end
endmodule